// File: doc/BRIEF.md
# Serial Data-Link Transmitter with Shared Ring/HDLC Buffer

This block feeds a low-rate serial signalling channel that lives inside a framed line. The framer announces each bit position of the line with a strobe plus the position's coordinates: time slot, bit within the slot, whether it is the framing bit, and whether the current frame is odd. The block compares those coordinates with its configured selection. On every strobe that falls on a selected position it presents one channel bit in that same cycle. The channel rate is set by which positions are chosen. Each bit per frame adds 8 kbps, and taking odd or even frames only halves that to 4 kbps.

A single 64-entry byte store backs the channel and is used in one of two roles. In ring mode it is a circular store of programmable length that replays its bytes over and over. In HDLC mode it is a FIFO: each entry carries an end-of-message mark, and the queued bytes go out as framed packets. Each packet has flags, zero insertion and a 16-bit frame check sequence. When nothing is queued, the channel idles with flags. If the queue runs dry before the marked byte, the packet is aborted and a sticky underrun indication is raised. The mode is chosen while reset is held.

Top module: `dlink_tx`

## Requirements
- R1: `tx_take` is high exactly when `strobe` is high, the frame filter passes, and the position matches the selection. With `sel_fbit`=1 the position matches when `pos_fbit`=1. With `sel_fbit`=0 it matches when `pos_fbit`=0, `pos_slot`=`sel_slot` and bit `pos_bit` of `sel_mask` is 1.
- R2: Frame filter encoding of `frame_pick`: 2'b01 passes only when `pos_odd`=1, 2'b10 passes only when `pos_odd`=0, and 2'b00 or 2'b11 always pass.
- R3: In ring mode (`hdlc_mode`=0) the channel sends the bytes at addresses 0 to `ring_len_m1` in order. Each byte goes least significant bit first, one bit per `tx_take` cycle, on `tx_bit` in that same cycle. After the last byte the sequence wraps back to address 0.
- R4: In ring mode, writes land at consecutive addresses, starting at 0 after reset and wrapping to 0 after address `ring_len_m1`. A later write to an address overwrites the earlier byte there.
- R5: In HDLC mode, while no byte is queued, the channel sends the flag octet 0x7E least significant bit first, repeated. The first bits after reset form such a flag.
- R6: In HDLC mode, at the end of a flag with bytes queued, a packet starts. Its bytes go out least significant bit first, followed by the complement of a CRC-16. The CRC is reflected polynomial 0x8408, initial value 0xFFFF, sent least significant bit first. A zero is inserted after every five consecutive ones in the bytes and the check sequence. Then a closing flag follows. The byte written with `wr_eom`=1 is the packet's last.
- R7: In HDLC mode, if the queue is empty when a byte without end mark has been sent, the channel sends eight ones and then a flag, and `underrun` rises and stays high until reset.
- R8: In HDLC mode the FIFO holds 64 bytes. `fifo_full` is high when 64 are queued, and a write while full is discarded.
- R9: In HDLC mode `fifo_empty` is high when no byte is queued, and `fifo_low` is high when the number of queued bytes is below `fill_thr`.
- R10: Several packets queued back to back go out in write order, and the closing flag of one packet also opens the next.
- R11: After reset `fifo_empty`=1, `fifo_full`=0 and `underrun`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| hdlc_mode | input | 1 | 1 = HDLC FIFO, 0 = replaying ring |
| ring_len_m1 | input | 6 | Ring length minus one |
| wr_en | input | 1 | Byte write strobe |
| wr_byte | input | 8 | Byte to store |
| wr_eom | input | 1 | Marks the written byte as last of a packet |
| fill_thr | input | 7 | Level below which `fifo_low` is raised |
| sel_fbit | input | 1 | Channel uses the framing bit |
| sel_slot | input | 5 | Selected time slot |
| sel_mask | input | 8 | Selected bits inside the slot |
| frame_pick | input | 2 | Frame filter: all, odd or even |
| strobe | input | 1 | Framer bit-position strobe |
| pos_fbit | input | 1 | Current position is the framing bit |
| pos_slot | input | 5 | Current time slot |
| pos_bit | input | 3 | Current bit within the slot |
| pos_odd | input | 1 | Current frame is odd |
| tx_take | output | 1 | This position carries a channel bit |
| tx_bit | output | 1 | Channel bit for this position |
| fifo_empty | output | 1 | No byte queued |
| fifo_full | output | 1 | 64 bytes queued |
| fifo_low | output | 1 | Queue level below `fill_thr` |
| underrun | output | 1 | Sticky packet-abort indication |

## Verification
The HDLC path is driven with the strobe on every cycle, which shows the raw serial stream. It is first driven with an empty queue, then with packets that hold long runs of ones and a byte equal to the flag, which exposes zero insertion and check-sequence errors. Two packets queued together show ordering and the shared flag. A 64-byte packet with an extra write exposes the full limit. A packet left without its end mark separates abort handling from normal closing. Random framer positions under odd, even and framing-bit filters exercise the selection logic while data still flows. The ring is loaded past its length to show wrapping writes and replay.

// File: rtl/dlink_pkg.sv
package dlink_pkg;

    typedef enum logic [1:0] {
        PICK_ALL  = 2'b00,
        PICK_ODD  = 2'b01,
        PICK_EVEN = 2'b10,
        PICK_BOTH = 2'b11
    } frame_pick_t;

    typedef enum logic [1:0] {
        ST_FLAG,
        ST_DATA,
        ST_FCS,
        ST_ABORT
    } hdlc_state_t;

    typedef struct packed {
        logic       eom;
        logic [7:0] data;
    } buf_word_t;

    localparam logic [7:0]  FLAG_OCTET    = 8'h7E;
    localparam logic [15:0] FCS_POLY_REFL = 16'h8408;
    localparam logic [15:0] FCS_INIT      = 16'hFFFF;
    localparam logic [2:0]  STUFF_RUN     = 3'd5;

    function automatic logic [15:0] fcs_next(input logic [15:0] c, input logic b);
        logic fb;
        fb = c[0] ^ b;
        return fb ? ((c >> 1) ^ FCS_POLY_REFL) : (c >> 1);
    endfunction

endpackage

// File: rtl/dlink_slot_sel.sv
module dlink_slot_sel
    import dlink_pkg::*;
#(
    parameter int SLOT_W = 5,
    parameter int LANE_N = 8,
    localparam int LANE_W = $clog2(LANE_N)
) (
    input  logic              strobe,
    input  logic              pos_fbit,
    input  logic              pos_odd,
    input  logic [SLOT_W-1:0] pos_slot,
    input  logic [LANE_W-1:0] pos_bit,
    input  logic              sel_fbit,
    input  logic [SLOT_W-1:0] sel_slot,
    input  logic [LANE_N-1:0] sel_mask,
    input  logic [1:0]        frame_pick,
    output logic              take
);
    logic frame_ok;
    logic pos_hit;

    always_comb begin
        unique case (frame_pick_t'(frame_pick))
            PICK_ODD:  frame_ok = pos_odd;
            PICK_EVEN: frame_ok = !pos_odd;
            default:   frame_ok = 1'b1;
        endcase
        if (sel_fbit) pos_hit = pos_fbit;
        else          pos_hit = !pos_fbit && (pos_slot == sel_slot) && sel_mask[pos_bit];
        take = strobe && frame_ok && pos_hit;
    end
endmodule

// File: rtl/dlink_buf.sv
module dlink_buf
    import dlink_pkg::*;
#(
    parameter int DEPTH = 64,
    localparam int AW = $clog2(DEPTH),
    localparam int CW = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          hdlc_mode,
    input  logic [AW-1:0] ring_last,
    input  logic          wr_en,
    input  buf_word_t     wr_word,
    input  logic          pop,
    input  logic [AW-1:0] raw_addr,
    input  logic [CW-1:0] fill_thr,
    output buf_word_t     rd_word,
    output logic          empty,
    output logic          full,
    output logic          low
);
    buf_word_t     mem [DEPTH];
    logic [AW-1:0] wr_ptr, rd_ptr, wrap_at;
    logic [CW-1:0] count;
    logic          accept, do_pop;

    assign full    = (count == CW'(DEPTH));
    assign empty   = (count == '0);
    assign low     = (count < fill_thr);
    assign accept  = wr_en && (!hdlc_mode || !full);
    assign do_pop  = pop && hdlc_mode && !empty;
    assign wrap_at = hdlc_mode ? AW'(DEPTH - 1) : ring_last;
    assign rd_word = mem[hdlc_mode ? rd_ptr : raw_addr];

    always_ff @(posedge clk) begin
        if (accept) mem[wr_ptr] <= wr_word;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (accept) wr_ptr <= (wr_ptr == wrap_at) ? '0 : wr_ptr + 1'b1;
            if (do_pop) rd_ptr <= (rd_ptr == AW'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
            count <= count + CW'(accept && hdlc_mode) - CW'(do_pop);
        end
    end

    assert_no_overflow_R8: assert property (@(posedge clk) disable iff (rst)
        count <= CW'(DEPTH));
    assert_full_discard_R8: assert property (@(posedge clk) disable iff (rst)
        (hdlc_mode && full && !pop) |=> full);
    assert_no_pop_empty_R7: assert property (@(posedge clk) disable iff (rst)
        !(pop && hdlc_mode && empty));
endmodule

// File: rtl/dlink_ring.sv
module dlink_ring #(
    parameter int DEPTH = 64,
    localparam int AW = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          en,
    input  logic          take,
    input  logic [AW-1:0] ring_last,
    input  logic [7:0]    rd_data,
    output logic [AW-1:0] addr,
    output logic          bit_out
);
    logic [2:0] bi;

    assign bit_out = rd_data[bi];

    always_ff @(posedge clk) begin
        if (rst) begin
            addr <= '0;
            bi   <= '0;
        end else if (en && take) begin
            bi <= bi + 3'd1;
            if (bi == 3'd7) addr <= (addr >= ring_last) ? '0 : addr + 1'b1;
        end
    end

    assert_ring_wrap_R3: assert property (@(posedge clk) disable iff (rst)
        (en && take && bi == 3'd7 && addr == ring_last) |=> (addr == '0));
endmodule

// File: rtl/dlink_hdlc.sv
module dlink_hdlc
    import dlink_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      hdlc_mode,
    input  logic      take,
    input  buf_word_t head,
    input  logic      empty,
    output logic      pop,
    output logic      bit_out,
    output logic      underrun
);
    hdlc_state_t st;
    logic [3:0]  idx;
    logic [2:0]  ones;
    logic [7:0]  sh;
    logic        sh_eom;
    logic [15:0] crc;
    logic        cur, stuff_now, load, step;

    always_comb begin
        unique case (st)
            ST_FLAG: cur = FLAG_OCTET[idx[2:0]];
            ST_DATA: cur = sh[idx[2:0]];
            ST_FCS:  cur = ~crc[0];
            default: cur = 1'b1;
        endcase
        stuff_now = (st != ST_ABORT) && (ones == STUFF_RUN);
        load = (idx == 4'd7) && !empty &&
               ((st == ST_FLAG) || (st == ST_DATA && !sh_eom));
        step = hdlc_mode && take && !stuff_now;
        pop = step && load;
        bit_out = stuff_now ? 1'b0 : cur;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st       <= ST_FLAG;
            idx      <= '0;
            ones     <= '0;
            sh       <= '0;
            sh_eom   <= 1'b0;
            crc      <= FCS_INIT;
            underrun <= 1'b0;
        end else if (hdlc_mode && take) begin
            if (stuff_now) begin
                ones <= '0;
            end else begin
                unique case (st)
                    ST_FLAG: begin
                        ones <= '0;
                        idx  <= (idx == 4'd7) ? '0 : idx + 4'd1;
                        if (load) begin
                            st     <= ST_DATA;
                            sh     <= head.data;
                            sh_eom <= head.eom;
                            crc    <= FCS_INIT;
                        end
                    end
                    ST_DATA: begin
                        crc  <= fcs_next(crc, cur);
                        ones <= cur ? ones + 3'd1 : '0;
                        if (idx == 4'd7) begin
                            idx <= '0;
                            if (sh_eom) begin
                                st <= ST_FCS;
                            end else if (load) begin
                                sh     <= head.data;
                                sh_eom <= head.eom;
                            end else begin
                                st       <= ST_ABORT;
                                underrun <= 1'b1;
                            end
                        end else begin
                            idx <= idx + 4'd1;
                        end
                    end
                    ST_FCS: begin
                        crc  <= {1'b1, crc[15:1]};
                        ones <= cur ? ones + 3'd1 : '0;
                        if (idx == 4'd15) begin
                            idx <= '0;
                            st  <= ST_FLAG;
                        end else begin
                            idx <= idx + 4'd1;
                        end
                    end
                    default: begin
                        ones <= '0;
                        if (idx == 4'd7) begin
                            idx <= '0;
                            st  <= ST_FLAG;
                        end else begin
                            idx <= idx + 4'd1;
                        end
                    end
                endcase
            end
        end
    end

    assert_stuff_limit_R6: assert property (@(posedge clk) disable iff (rst)
        ones <= STUFF_RUN);
    assert_underrun_sticky_R7: assert property (@(posedge clk) disable iff (rst)
        underrun |=> underrun);
    assert_underrun_abort_R7: assert property (@(posedge clk) disable iff (rst)
        $rose(underrun) |-> (st == ST_ABORT));
endmodule

// File: rtl/dlink_tx.sv
module dlink_tx
    import dlink_pkg::*;
#(
    parameter int DEPTH  = 64,
    parameter int SLOT_W = 5,
    parameter int LANE_N = 8,
    localparam int AW = $clog2(DEPTH),
    localparam int CW = $clog2(DEPTH + 1),
    localparam int LANE_W = $clog2(LANE_N)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              hdlc_mode,
    input  logic [AW-1:0]     ring_len_m1,
    input  logic              wr_en,
    input  logic [7:0]        wr_byte,
    input  logic              wr_eom,
    input  logic [CW-1:0]     fill_thr,
    input  logic              sel_fbit,
    input  logic [SLOT_W-1:0] sel_slot,
    input  logic [LANE_N-1:0] sel_mask,
    input  logic [1:0]        frame_pick,
    input  logic              strobe,
    input  logic              pos_fbit,
    input  logic [SLOT_W-1:0] pos_slot,
    input  logic [LANE_W-1:0] pos_bit,
    input  logic              pos_odd,
    output logic              tx_take,
    output logic              tx_bit,
    output logic              fifo_empty,
    output logic              fifo_full,
    output logic              fifo_low,
    output logic              underrun
);
    buf_word_t     wr_word, rd_word;
    logic          pop, ring_bit, hdlc_bit;
    logic [AW-1:0] raw_addr;

    assign wr_word = '{eom: wr_eom, data: wr_byte};
    assign tx_bit  = hdlc_mode ? hdlc_bit : ring_bit;

    dlink_slot_sel #(.SLOT_W(SLOT_W), .LANE_N(LANE_N)) u_sel (
        .strobe(strobe), .pos_fbit(pos_fbit), .pos_odd(pos_odd),
        .pos_slot(pos_slot), .pos_bit(pos_bit), .sel_fbit(sel_fbit),
        .sel_slot(sel_slot), .sel_mask(sel_mask), .frame_pick(frame_pick),
        .take(tx_take)
    );

    dlink_buf #(.DEPTH(DEPTH)) u_buf (
        .clk(clk), .rst(rst), .hdlc_mode(hdlc_mode), .ring_last(ring_len_m1),
        .wr_en(wr_en), .wr_word(wr_word), .pop(pop), .raw_addr(raw_addr),
        .fill_thr(fill_thr), .rd_word(rd_word), .empty(fifo_empty),
        .full(fifo_full), .low(fifo_low)
    );

    dlink_ring #(.DEPTH(DEPTH)) u_ring (
        .clk(clk), .rst(rst), .en(!hdlc_mode), .take(tx_take),
        .ring_last(ring_len_m1), .rd_data(rd_word.data), .addr(raw_addr),
        .bit_out(ring_bit)
    );

    dlink_hdlc u_hdlc (
        .clk(clk), .rst(rst), .hdlc_mode(hdlc_mode), .take(tx_take),
        .head(rd_word), .empty(fifo_empty), .pop(pop), .bit_out(hdlc_bit),
        .underrun(underrun)
    );

    assert_take_needs_strobe_R1: assert property (@(posedge clk) disable iff (rst)
        !strobe |-> !tx_take);
    assert_fbit_only_R1: assert property (@(posedge clk) disable iff (rst)
        (sel_fbit && !pos_fbit) |-> !tx_take);
endmodule

// File: tb/test_dlink_tx.sv
module test_dlink_tx;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       hdlc_mode = 1'b1;
    logic [5:0] ring_len_m1 = '0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_byte = '0;
    logic       wr_eom = 1'b0;
    logic [6:0] fill_thr = 7'd4;
    logic       sel_fbit = 1'b0;
    logic [4:0] sel_slot = 5'd3;
    logic [7:0] sel_mask = 8'hFF;
    logic [1:0] frame_pick = 2'b00;
    logic       strobe = 1'b0;
    logic       pos_fbit = 1'b0;
    logic [4:0] pos_slot = '0;
    logic [2:0] pos_bit = '0;
    logic       pos_odd = 1'b0;
    logic       tx_take, tx_bit, fifo_empty, fifo_full, fifo_low, underrun;

    dlink_tx i_dlink_tx (
        .clk(clk), .rst(rst), .hdlc_mode(hdlc_mode), .ring_len_m1(ring_len_m1),
        .wr_en(wr_en), .wr_byte(wr_byte), .wr_eom(wr_eom), .fill_thr(fill_thr),
        .sel_fbit(sel_fbit), .sel_slot(sel_slot), .sel_mask(sel_mask),
        .frame_pick(frame_pick), .strobe(strobe), .pos_fbit(pos_fbit),
        .pos_slot(pos_slot), .pos_bit(pos_bit), .pos_odd(pos_odd),
        .tx_take(tx_take), .tx_bit(tx_bit), .fifo_empty(fifo_empty),
        .fifo_full(fifo_full), .fifo_low(fifo_low), .underrun(underrun)
    );

    always #2.5 clk = ~clk;

    int    checks = 0;
    int    errors = 0;
    bit    finished = 1'b0;
    string cur_req = "R5";

    int bq[$];
    int mq[$];
    int rmem[64];
    int rwr, rrd, rbi;

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d t=%0t", req, what, act, exp, $time);
        end
    endtask

    function automatic bit exp_take();
        bit fr, hit;
        if (frame_pick == 2'b01)      fr = pos_odd;
        else if (frame_pick == 2'b10) fr = !pos_odd;
        else                          fr = 1'b1;
        if (sel_fbit) hit = pos_fbit;
        else hit = !pos_fbit && pos_slot == sel_slot && sel_mask[pos_bit];
        return strobe && fr && hit;
    endfunction

    task automatic push_flag();
        for (int i = 0; i < 8; i++) bq.push_back((8'h7E >> i) & 1);
    endtask

    task automatic build_frame();
        int raw[$];
        int crc = 16'hFFFF;
        int ones = 0;
        bit ended = 1'b0;
        while (mq.size() > 0 && !ended) begin
            int w = mq.pop_front();
            for (int b = 0; b < 8; b++) begin
                int x = (w >> b) & 1;
                int fb = (crc ^ x) & 1;
                raw.push_back(x);
                crc = crc >> 1;
                if (fb != 0) crc = crc ^ 16'h8408;
            end
            ended = w[8];
        end
        if (ended) for (int b = 0; b < 16; b++) raw.push_back(((~crc) >> b) & 1);
        foreach (raw[i]) begin
            bq.push_back(raw[i]);
            ones = raw[i] ? ones + 1 : 0;
            if (ones == 5) begin
                bq.push_back(0);
                ones = 0;
            end
        end
        if (!ended) for (int i = 0; i < 8; i++) bq.push_back(1);
        push_flag();
    endtask

    task automatic tick();
        bit et;
        int eb;
        #1;
        et = exp_take();
        check(tx_take === et, "R1", "tx_take", int'(tx_take), int'(et));
        if (et) begin
            if (hdlc_mode) eb = bq[0];
            else           eb = (rmem[rrd] >> rbi) & 1;
            check(tx_bit === eb[0], cur_req, "tx_bit", int'(tx_bit), eb);
        end
        @(posedge clk);
        if (et) begin
            if (hdlc_mode) begin
                void'(bq.pop_front());
                if (bq.size() == 0) begin
                    if (mq.size() > 0) build_frame();
                    else push_flag();
                end
            end else begin
                if (rbi == 7) begin
                    rbi = 0;
                    rrd = (rrd >= int'(ring_len_m1)) ? 0 : rrd + 1;
                end else begin
                    rbi++;
                end
            end
        end
        if (wr_en) begin
            if (hdlc_mode) begin
                if (mq.size() < 64) mq.push_back({wr_eom, wr_byte});
            end else begin
                rmem[rwr] = wr_byte;
                rwr = (rwr == int'(ring_len_m1)) ? 0 : rwr + 1;
            end
        end
        @(negedge clk);
    endtask

    task automatic do_reset(input bit mode);
        @(negedge clk);
        rst = 1'b1;
        hdlc_mode = mode;
        strobe = 1'b0;
        wr_en = 1'b0;
        repeat (2) @(negedge clk);
        bq.delete();
        mq.delete();
        push_flag();
        rwr = 0; rrd = 0; rbi = 0;
        rst = 1'b0;
    endtask

    task automatic put(input int b, input bit eom);
        strobe = 1'b0;
        wr_en = 1'b1;
        wr_byte = b[7:0];
        wr_eom = eom;
        tick();
        wr_en = 1'b0;
        wr_eom = 1'b0;
    endtask

    task automatic run(input int n, input bit rnd);
        for (int i = 0; i < n; i++) begin
            strobe = 1'b1;
            if (rnd) begin
                pos_fbit = ($urandom_range(0, 7) == 0);
                pos_slot = ($urandom_range(0, 1) == 0) ? sel_slot : 5'($urandom_range(0, 31));
                pos_bit  = 3'($urandom_range(0, 7));
                pos_odd  = 1'($urandom_range(0, 1));
                strobe   = ($urandom_range(0, 3) != 0);
            end else begin
                pos_fbit = sel_fbit;
                pos_slot = sel_slot;
                pos_bit  = 3'(i);
                pos_odd  = i[3];
            end
            tick();
        end
        strobe = 1'b0;
    endtask

    task automatic status(input string req, input bit e_emp, input bit e_full,
                          input bit e_low, input bit e_und);
        #1;
        check(fifo_empty === e_emp, req, "fifo_empty", int'(fifo_empty), int'(e_emp));
        check(fifo_full === e_full, req, "fifo_full", int'(fifo_full), int'(e_full));
        check(fifo_low === e_low, req, "fifo_low", int'(fifo_low), int'(e_low));
        check(underrun === e_und, req, "underrun", int'(underrun), int'(e_und));
    endtask

    initial begin
        #(5ns * 150000);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        do_reset(1'b1);
        status("R11", 1, 0, 1, 0);

        cur_req = "R5";
        run(40, 0);

        cur_req = "R6";
        put(8'hFF, 0); put(8'h3E, 0); put(8'h81, 1);
        status("R9", 0, 0, 1, 0);
        run(120, 0);
        status("R6", 1, 0, 1, 0);

        cur_req = "R10";
        put(8'h7E, 0); put(8'h55, 1); put(8'hF8, 0); put(8'h1F, 1);
        status("R9", 0, 0, 0, 0);
        run(140, 0);

        cur_req = "R2";
        put(8'hC3, 0); put(8'hFC, 0); put(8'h0D, 1);
        sel_mask = 8'h81;
        frame_pick = 2'b01; run(300, 1);
        frame_pick = 2'b10; run(300, 1);
        frame_pick = 2'b11; sel_fbit = 1'b1; run(300, 1);
        sel_fbit = 1'b0; frame_pick = 2'b00; sel_mask = 8'hFF;
        run(120, 0);

        cur_req = "R8";
        do_reset(1'b1);
        for (int i = 0; i < 64; i++) put((i * 37 + 5) & 8'hFF, i == 63);
        status("R8", 0, 1, 0, 0);
        put(8'hA0, 1);
        status("R8", 0, 1, 0, 0);
        run(800, 0);
        status("R8", 1, 0, 1, 0);

        cur_req = "R9";
        do_reset(1'b1);
        put(8'h11, 0); put(8'h22, 0); put(8'h33, 0);
        status("R9", 0, 0, 1, 0);
        put(8'h44, 1);
        status("R9", 0, 0, 0, 0);
        run(100, 0);

        cur_req = "R7";
        do_reset(1'b1);
        put(8'h12, 0); put(8'h34, 0);
        run(60, 0);
        status("R7", 1, 0, 1, 1);
        put(8'h5A, 1);
        run(80, 0);
        status("R7", 1, 0, 1, 1);

        cur_req = "R3";
        ring_len_m1 = 6'd2;
        do_reset(1'b0);
        put(8'hA5, 0); put(8'h3C, 0); put(8'h0F, 0);
        run(30, 0);
        cur_req = "R4";
        put(8'h96, 0); put(8'hC3, 0);
        run(60, 0);
        cur_req = "R3";
        sel_mask = 8'h24;
        run(300, 1);

        finished = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule